// File: doc/BRIEF.md
# Bit-Serial Byte-Lane Memory Port

This block sits between a bit-serial processor datapath and a 32-bit parallel memory bus made of four 8-bit byte lanes. The processor shifts a byte address into a hold-capable address shifter, one bit per cycle and least-significant bit first. The upper address bits drive the bus word address. The lowest two bits pick a byte lane. A 32-bit data shifter either collects serial write data or captures the parallel bus on a read and then streams it back one bit at a time.

A start pulse with a command (read or write, word or byte, sign extension on or off) runs a short bus sequence. A read holds chip-enable and output-enable for two cycles and captures the bus at the end of the second. A write holds chip-enable for two cycles and pulses per-lane write strobes in the first. The strobes are decoded inside the block, so the bus never carries a word/byte signal.

Serial data moves over two one-bit valid/ready streams. Input beats are taken only when `sin_valid` and `sin_ready` are both high. On the output stream, while `sout_valid` is high and `sout_ready` is low, `sout_bit` holds its value and no bit is consumed. Start requests are ignored while a bus sequence runs or while readout bits remain.

Top module: `serial_mem_port`

## Requirements
- R1: After reset, `mem_ce`, `mem_oe`, `mem_we`, `busy`, `sout_valid` are low, `mem_word_addr` is zero and `mem_wdata` is zero.
- R2: When `addr_load` is high, the address shifter takes `addr_sin` into its top bit and moves the rest down one place, so the address is sent LSB first. When `addr_load` is low it holds. `mem_word_addr` is the address without its two lowest bits.
- R3: `sin_ready` is high only when no bus sequence runs, no readout is pending and `start` is low. Each accepted beat enters bit 31 of the data shifter, which moves down one place. `mem_wdata` always shows the shifter, so 32 beats load a word LSB first.
- R4: A start with `cmd_write`=0 raises `mem_ce`, `mem_oe` and `busy` for exactly the two cycles after the start edge. The bus value present in the second cycle is captured at its end.
- R5: A start with `cmd_write`=1 raises `mem_ce` and `busy` for two cycles. `mem_we` is high only in the first of them, with `mem_oe` low. For a word write all four strobe bits are set.
- R6: On a byte write, strobe bit n alone is set, where n is the address's two lowest bits and lane n spans data bits 8n+7..8n. At the start edge, the shifter's bits 31:24 are copied into all four lanes.
- R7: After a word read, `sout_valid` stays high for 32 accepted beats. They carry the captured word from bit 0 upward. `sout_bit` is steady while the beat waits on `sout_ready`.
- R8: After a byte read, the first 8 beats carry the selected lane from its bit 0 upward. With `cmd_sext`=0, the remaining 24 beats are zero.
- R9: With `cmd_sext`=1 on a byte read, the remaining 24 beats all equal bit 7 of the selected lane.
- R10: A start raised while `busy` is high, or while readout beats remain (including the cycle of the final beat), causes no bus activity and leaves memory unchanged.
- R11: With `addr_load` low during a byte readout, toggling `addr_sin` changes neither the address nor the lane being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Shift enable of the address shifter |
| addr_sin | input | 1 | Serial address bit |
| sin_valid | input | 1 | Serial write-data beat valid |
| sin_ready | output | 1 | Serial write-data beat accepted |
| sin_bit | input | 1 | Serial write-data bit |
| sout_valid | output | 1 | Serial read-data beat valid |
| sout_ready | input | 1 | Consumer takes the read-data beat |
| sout_bit | output | 1 | Serial read-data bit |
| start | input | 1 | Begin a bus sequence |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_byte | input | 1 | 1 byte access, 0 word access |
| cmd_sext | input | 1 | Sign-extend byte reads |
| busy | output | 1 | Bus sequence in progress |
| mem_word_addr | output | AW-2 | Bus word address |
| mem_wdata | output | 32 | Data driven to the bus |
| mem_rdata | input | 32 | Data returned from the bus |
| mem_ce | output | 1 | Chip enable, active high |
| mem_oe | output | 1 | Output enable, active high |
| mem_we | output | 4 | Per-lane write strobes, active high |

## Verification
Two collisions can happen in one cycle. The first is a start arriving with the last accepted readout beat. The bench raises `start` on exactly that beat and then requires `busy` and the strobes to stay low, with memory unchanged on a later read. The second is a start meeting a valid serial input beat. The reference model expects `sin_ready` to drop in that cycle, so the beat is neither taken nor lost. A second start issued one cycle into a read is judged the same way.

// File: rtl/smp_pkg.sv
package smp_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RD_OPEN,
    PH_RD_LATCH,
    PH_WR_PULSE,
    PH_WR_SETTLE
  } phase_e;

  typedef struct packed {
    logic write;
    logic byte_mode;
    logic sext;
  } cmd_t;
endpackage

// File: rtl/smp_addr_reg.sv
module smp_addr_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          bit_in,
  output logic [AW-1:0] addr_q
);
  // Hold-capable shifter: moves only while shift_en is high.
  always_ff @(posedge clk) begin
    if (!rst_n)        addr_q <= '0;
    else if (shift_en) addr_q <= {bit_in, addr_q[AW-1:1]};
  end
endmodule

// File: rtl/smp_data_reg.sv
module smp_data_reg #(
  parameter int LANE_W    = 8,
  parameter int NUM_LANES = 4,
  localparam int DW       = LANE_W * NUM_LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] cap_data,
  input  logic          rep_en,
  input  logic          in_fire,
  input  logic          in_bit,
  input  logic          out_fire,
  output logic [DW-1:0] data_q
);
  logic [DW-1:0] rep_val;

  // Top lane copied to every lane for byte writes.
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_rep
    assign rep_val[g*LANE_W +: LANE_W] = data_q[DW-1 -: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        data_q <= '0;
    else if (cap_en)   data_q <= cap_data;
    else if (rep_en)   data_q <= rep_val;
    else if (in_fire)  data_q <= {in_bit, data_q[DW-1:1]};
    else if (out_fire) data_q <= {1'b0, data_q[DW-1:1]};
  end
endmodule

// File: rtl/smp_bus_seq.sv
module smp_bus_seq
  import smp_pkg::*;
#(
  parameter int NUM_LANES = 4,
  localparam int SELW     = $clog2(NUM_LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_ok,
  input  cmd_t                 cmd_in,
  input  logic [SELW-1:0]      lane_sel,
  output cmd_t                 cmd_q,
  output logic                 ce,
  output logic                 oe,
  output logic [NUM_LANES-1:0] we,
  output logic                 busy,
  output logic                 cap_en,
  output logic                 rep_en
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:      if (start_ok) phase_d = cmd_in.write ? PH_WR_PULSE : PH_RD_OPEN;
      PH_RD_OPEN:   phase_d = PH_RD_LATCH;
      PH_RD_LATCH:  phase_d = PH_IDLE;
      PH_WR_PULSE:  phase_d = PH_WR_SETTLE;
      PH_WR_SETTLE: phase_d = PH_IDLE;
      default:      phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cmd_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (start_ok) cmd_q <= cmd_in;
    end
  end

  assign busy   = (phase_q != PH_IDLE);
  assign ce     = busy;
  assign oe     = (phase_q == PH_RD_OPEN) || (phase_q == PH_RD_LATCH);
  assign cap_en = (phase_q == PH_RD_LATCH);
  assign rep_en = start_ok && cmd_in.write && cmd_in.byte_mode;

  // Strobe decode at the processor side: one lane for bytes, all for words.
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_we
    logic lane_hit;
    assign lane_hit = (lane_sel == g[SELW-1:0]);
    assign we[g]    = (phase_q == PH_WR_PULSE) && (!cmd_q.byte_mode || lane_hit);
  end
endmodule

// File: rtl/smp_readout.sv
module smp_readout #(
  parameter int LANE_W    = 8,
  parameter int NUM_LANES = 4,
  localparam int DW       = LANE_W * NUM_LANES,
  localparam int SELW     = $clog2(NUM_LANES),
  localparam int CW       = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_en,
  input  logic [DW-1:0]   cap_data,
  input  logic [DW-1:0]   data_q,
  input  logic [SELW-1:0] lane_sel,
  input  logic            byte_mode,
  input  logic            sext,
  input  logic            out_ready,
  output logic            out_valid,
  output logic            out_bit,
  output logic            out_fire
);
  logic [CW-1:0]        cnt_q;
  logic                 active_q;
  logic                 sign_q;
  logic [NUM_LANES-1:0] lane_lsb;
  logic [NUM_LANES-1:0] lane_msb;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign lane_lsb[g] = data_q[g*LANE_W];
    assign lane_msb[g] = cap_data[g*LANE_W + LANE_W - 1];
  end

  assign out_valid = active_q;
  assign out_fire  = active_q && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sign_q   <= 1'b0;
    end else if (cap_en) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      sign_q   <= lane_msb[lane_sel];
    end else if (out_fire) begin
      if (cnt_q == CW'(DW - 1)) active_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Whole register shifts down, so each lane's bit 0 walks through the lane.
  always_comb begin
    if (!byte_mode)                out_bit = data_q[0];
    else if (cnt_q < CW'(LANE_W))  out_bit = lane_lsb[lane_sel];
    else                           out_bit = sext & sign_q;
  end
endmodule

// File: rtl/serial_mem_port.sv
module serial_mem_port
  import smp_pkg::*;
#(
  parameter int AW        = 16,
  parameter int LANE_W    = 8,
  parameter int NUM_LANES = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  addr_load,
  input  logic                                  addr_sin,
  input  logic                                  sin_valid,
  output logic                                  sin_ready,
  input  logic                                  sin_bit,
  output logic                                  sout_valid,
  input  logic                                  sout_ready,
  output logic                                  sout_bit,
  input  logic                                  start,
  input  logic                                  cmd_write,
  input  logic                                  cmd_byte,
  input  logic                                  cmd_sext,
  output logic                                  busy,
  output logic [AW-$clog2(NUM_LANES)-1:0]       mem_word_addr,
  output logic [LANE_W*NUM_LANES-1:0]           mem_wdata,
  input  logic [LANE_W*NUM_LANES-1:0]           mem_rdata,
  output logic                                  mem_ce,
  output logic                                  mem_oe,
  output logic [NUM_LANES-1:0]                  mem_we
);
  localparam int DW   = LANE_W * NUM_LANES;
  localparam int SELW = $clog2(NUM_LANES);

  logic [AW-1:0]   addr_q;
  logic [SELW-1:0] lane_sel;
  logic [DW-1:0]   data_q;
  cmd_t            cmd_in, cmd_q;
  logic            start_ok, sin_fire, out_fire, cap_en, rep_en;

  assign cmd_in        = {cmd_write, cmd_byte, cmd_sext};
  assign lane_sel      = addr_q[SELW-1:0];
  assign mem_word_addr = addr_q[AW-1:SELW];
  assign mem_wdata     = data_q;
  assign start_ok      = start && !busy && !sout_valid;
  assign sin_ready     = !busy && !sout_valid && !start;
  assign sin_fire      = sin_valid && sin_ready;

  smp_addr_reg #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .shift_en(addr_load), .bit_in(addr_sin), .addr_q(addr_q)
  );

  smp_data_reg #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_data (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_data(mem_rdata), .rep_en(rep_en),
    .in_fire(sin_fire), .in_bit(sin_bit), .out_fire(out_fire), .data_q(data_q)
  );

  smp_bus_seq #(.NUM_LANES(NUM_LANES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .cmd_in(cmd_in), .lane_sel(lane_sel),
    .cmd_q(cmd_q), .ce(mem_ce), .oe(mem_oe), .we(mem_we), .busy(busy),
    .cap_en(cap_en), .rep_en(rep_en)
  );

  smp_readout #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_rdo (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_data(mem_rdata), .data_q(data_q),
    .lane_sel(lane_sel), .byte_mode(cmd_q.byte_mode), .sext(cmd_q.sext),
    .out_ready(sout_ready), .out_valid(sout_valid), .out_bit(sout_bit), .out_fire(out_fire)
  );
endmodule

// File: rtl/smp_checker.sv
module smp_checker #(
  parameter int WAW = 14,
  parameter int NL  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           addr_load,
  input logic           start,
  input logic           sin_ready,
  input logic           sout_valid,
  input logic           sout_ready,
  input logic           sout_bit,
  input logic           busy,
  input logic [WAW-1:0] mem_word_addr,
  input logic           mem_ce,
  input logic           mem_oe,
  input logic [NL-1:0]  mem_we
);
  // R4
  oe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_oe |-> mem_ce);
  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |=> busy ##1 !busy);
  // R5
  we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) (|mem_we) |-> (mem_ce && !mem_oe));
  // R6
  we_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_we) |-> ($countones(mem_we) == 1 || (&mem_we)));
  // R3
  sin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sin_ready |-> (!busy && !sout_valid && !start));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !addr_load |=> $stable(mem_word_addr));
  // R7
  sout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sout_valid && !sout_ready && !addr_load) |=> (sout_valid && $stable(sout_bit)));
  // R10
  start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) (sout_valid && start) |=> !busy);
endmodule

bind serial_mem_port smp_checker #(.WAW(AW - $clog2(NUM_LANES)), .NL(NUM_LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .start(start), .sin_ready(sin_ready),
  .sout_valid(sout_valid), .sout_ready(sout_ready), .sout_bit(sout_bit), .busy(busy),
  .mem_word_addr(mem_word_addr), .mem_ce(mem_ce), .mem_oe(mem_oe), .mem_we(mem_we)
);

// File: tb/serial_mem_port_test.sv
`timescale 1ns/1ps
module serial_mem_port_test;
  logic clk = 0, rst_n = 0;
  logic addr_load = 0, addr_sin = 0, sin_valid = 0, sin_bit = 0, sout_ready = 0;
  logic start = 0, cmd_write = 0, cmd_byte = 0, cmd_sext = 0;
  logic sin_ready, sout_valid, sout_bit, busy, mem_ce, mem_oe;
  logic [13:0] mem_word_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0]  mem_we;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_mem_port uut (.*);

  // Bus RAM driven by the design's strobes
  logic [31:0] ram [0:15];
  initial for (int i = 0; i < 16; i++) ram[i] = 32'h0;
  always @(posedge clk)
    for (int l = 0; l < 4; l++)
      if (mem_we[l]) ram[mem_word_addr[3:0]][8*l +: 8] <= mem_wdata[8*l +: 8];
  assign mem_rdata = (mem_ce && mem_oe) ? ram[mem_word_addr[3:0]] : 32'h0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int ph = 0, left = 0, idx = 0;
  bit [15:0] ma = 0;
  bit [31:0] md = 0, mword = 0;
  bit c_byte = 0, c_sx = 0, idle, ract, acc, fin, fout;
  bit [31:0] mmem [0:15];
  initial for (int i = 0; i < 16; i++) mmem[i] = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; left = 0; idx = 0; ma = 0; md = 0; mword = 0; c_byte = 0; c_sx = 0;
    end else begin
      idle = (ph == 0); ract = (left > 0);
      acc  = start && idle && !ract;
      fin  = sin_valid && idle && !ract && !start;
      fout = ract && sout_ready;
      if (ph == 2) begin mword = mmem[ma[5:2]]; md = mword; left = 32; idx = 0; end
      if (ph == 3)
        for (int l = 0; l < 4; l++)
          if (!c_byte || l == int'(ma[1:0])) mmem[ma[5:2]][8*l +: 8] = md[8*l +: 8];
      case (ph)
        1: ph = 2;
        2: ph = 0;
        3: ph = 4;
        4: ph = 0;
        default: if (acc) ph = cmd_write ? 3 : 1;
      endcase
      if (acc) begin
        c_byte = cmd_byte; c_sx = cmd_sext;
        if (cmd_write && cmd_byte) md = {4{md[31:24]}};
      end else if (fin) md = {sin_bit, md[31:1]};
      if (fout) begin md = md >> 1; idx++; left--; end
      if (addr_load) ma = {addr_sin, ma[15:1]};
    end
  end

  // Compare every cycle, after inputs driven at the falling edge have settled
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      int l;
      bit eb;
      l = int'(ma[1:0]);
      chk("R4 ce", mem_ce, (ph != 0));
      chk("R4 oe", mem_oe, (ph == 1 || ph == 2));
      chk("R4 busy", busy, (ph != 0));
      chk(c_byte ? "R6 we" : "R5 we", mem_we, (ph == 3) ? (c_byte ? (32'h1 << l) : 32'hF) : 32'h0);
      chk("R3 sin_ready", sin_ready, (ph == 0 && left == 0 && !start));
      chk("R3 wdata", mem_wdata, md);
      chk("R2 word_addr", mem_word_addr, ma[15:2]);
      chk("R7 sout_valid", sout_valid, (left > 0));
      if (left > 0) begin
        if (!c_byte) eb = mword[idx];
        else if (idx < 8) eb = mword[8*l + idx];
        else eb = c_sx & mword[8*l + 7];
        chk(!c_byte ? "R7 sout_bit" : (idx >= 8 && c_sx) ? "R9 sout_bit" : "R8 sout_bit", sout_bit, eb);
      end
    end
  end

  task automatic load_addr(input logic [15:0] a);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); addr_load = 1; addr_sin = a[i];
    end
    @(negedge clk); addr_load = 0;
  endtask

  task automatic push(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sin_valid = 1; sin_bit = w[i];
    end
    @(negedge clk); sin_valid = 0;
  endtask

  task automatic go(input bit wr, input bit byt, input bit sx, input bit again);
    @(negedge clk); start = 1; cmd_write = wr; cmd_byte = byt; cmd_sext = sx; sin_valid = 1;
    @(negedge clk); start = again; cmd_write = 1; cmd_byte = 0; sin_valid = 0;
    if (again) begin @(negedge clk); start = 0; end
    while (busy) @(negedge clk);
  endtask

  task automatic pull(input bit stall, input bit wiggle, input bit start_last, output logic [31:0] w);
    int k = 0, t = 0;
    w = '0;
    while (k < 32) begin
      @(negedge clk);
      if (wiggle) begin addr_load = 0; addr_sin = t[0]; end
      if (stall && (t % 3 == 1)) sout_ready = 0;
      else begin
        sout_ready = 1; w[k] = sout_bit;
        if (start_last && k == 31) begin start = 1; cmd_write = 1; cmd_byte = 0; end
        k++;
      end
      t++;
    end
    @(negedge clk); sout_ready = 0; start = 0;
  endtask

  logic [31:0] got;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    // R1 reset state
    chk("R1 ce", mem_ce, 0);
    chk("R1 oe", mem_oe, 0);
    chk("R1 we", mem_we, 0);
    chk("R1 busy", busy, 0);
    chk("R1 sout_valid", sout_valid, 0);
    chk("R1 word_addr", mem_word_addr, 0);
    chk("R1 wdata", mem_wdata, 0);

    // Word write then word read with back-pressure
    load_addr(16'h0010);
    push(32'hA5C31E7F, 32);
    #2 chk("R3 serial load", mem_wdata, 32'hA5C31E7F);
    go(1, 0, 0, 0);
    chk("R5 word written", ram[4], 32'hA5C31E7F);
    go(0, 0, 0, 0);
    pull(1, 0, 0, got);
    chk("R7 word readout", got, 32'hA5C31E7F);
    chk("R4 word read idle", busy, 0);

    // Byte write to lane 2
    load_addr(16'h0012);
    push(32'h0000009B, 8);
    go(1, 1, 0, 0);
    #2 chk("R6 replicated", mem_wdata, 32'h9B9B9B9B);
    chk("R6 lane only", ram[4], 32'hA59B1E7F);
    load_addr(16'h0010);
    go(0, 0, 0, 0);
    pull(0, 0, 0, got);
    chk("R6 read back", got, 32'hA59B1E7F);

    // Byte reads
    load_addr(16'h0012);
    go(0, 1, 0, 0);
    pull(1, 0, 0, got);
    chk("R8 zero fill", got, 32'h0000009B);
    go(0, 1, 1, 0);
    pull(0, 0, 0, got);
    chk("R9 sign fill", got, 32'hFFFFFF9B);
    load_addr(16'h0011);
    go(0, 1, 1, 0);
    pull(0, 0, 0, got);
    chk("R9 positive byte", got, 32'h0000001E);
    load_addr(16'h0013);
    go(0, 1, 1, 0);
    pull(1, 1, 0, got);
    chk("R11 lane held", got, 32'hFFFFFFA5);
    chk("R11 addr held", mem_word_addr, 14'd4);

    // Ignored starts
    load_addr(16'h0010);
    go(0, 0, 0, 1);
    pull(0, 0, 1, got);
    chk("R10 read unaffected", got, 32'hA59B1E7F);
    #2 chk("R10 no start after last beat", busy, 0);
    @(negedge clk); #2;
    chk("R10 still idle", busy, 0);
    chk("R10 memory kept", ram[4], 32'hA59B1E7F);
    go(0, 0, 0, 0);
    pull(0, 0, 0, got);
    chk("R10 reread", got, 32'hA59B1E7F);

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule